// File: doc/BRIEF.md
# Indirect Byte-Bus Mailbox Bridge

This block lets a host processor reach the byte-wide registers of two peripherals on an 8-bit multiplexed guest bus. The host sees only one 32-bit command/status word in its register window. One host write to that word starts exactly one guest-bus cycle. The word's fields choose the direction, which of the two guest devices is addressed, whether the cycle loads the guest's address latch or moves a byte through its data port, and the byte to send.

A complete guest register access always takes two commands. The first loads the register offset into the guest's address latch. The second reads or writes the guest's data port. While a cycle runs, a pending bit stays set. The host polls this bit before it issues the next command. When a read cycle finishes, the byte captured from the guest appears in the low byte of the same word.

To burst into a guest FIFO, the host reloads the address latch with the FIFO's fixed offset before every data byte. Device 0 uses offset 0x1E. Device 1 has two channels: the first at 0x1F, and the second 0x40 higher at 0x5F. A guest cycle keeps its chip select and one strobe asserted for a parameterised number of wait clocks, 4 by default.

Top module: `mbx_bridge`

## Requirements
- R1: While reset is applied and after it, the command word reads 0x00000000, every chip select is low, and the address-latch, write and read strobes are low.
- R2: The command word lives at byte offset 0x200 (parameter CMD_OFS). A read at any other offset returns zero. A write to any other offset starts no guest cycle.
- R3: Bit 25 of the command word is the pending flag. It becomes 1 in the clock after an accepted command write. It stays 1 for exactly WAIT_CLKS clocks and then returns to 0.
- R4: Bit 20 selects the guest device. A value of 0 raises gst_cs[0] and a value of 1 raises gst_cs[1]. The selected chip select is high only while the cycle is pending.
- R5: When bit 16 is 0, the cycle is an address-latch cycle whatever the value of bit 23. gst_ale is high, gst_doe is high, and gst_dout carries bits 7:0 of the command.
- R6: When bit 16 is 1 and bit 23 is 1, the cycle writes to the guest's data port. gst_wr is high, gst_doe is high, and gst_dout carries bits 7:0 of the command.
- R7: When bit 16 is 1 and bit 23 is 0, the cycle reads from the guest. gst_rd is high and gst_doe is low. gst_din is sampled on the last wait clock, and that byte is then returned in bits 7:0 of the command word.
- R8: A command write that arrives while the pending flag is 1 is ignored. The running cycle, its chip select and the stored fields do not change.
- R9: During a cycle exactly one of gst_ale, gst_wr and gst_rd is high, for exactly WAIT_CLKS clocks. All three are low when no cycle is pending.
- R10: Bits 23, 20 and 16 of the command word read back the direction, device and register select of the last accepted command. Bits 7:0 hold its payload until a read cycle replaces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one clock per write |
| host_addr | input | ADDR_W (12) | Host byte offset within the register window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on host_addr |
| gst_cs | output | 2 | Chip selects for guest device 0 and device 1 |
| gst_ale | output | 1 | Guest address-latch strobe |
| gst_wr | output | 1 | Guest data write strobe |
| gst_rd | output | 1 | Guest data read strobe |
| gst_dout | output | 8 | Byte driven onto the guest bus |
| gst_doe | output | 1 | Output enable for gst_dout |
| gst_din | input | 8 | Byte returned by the guest |

## Verification
The hardest case to reach is a second command that lands while a cycle is still pending. A host that polls correctly never issues one, so the stimulus writes a conflicting command on the clock right after an accepted one. That command names the other device, the other register select and the other direction. The bench then confirms that the chip select, the echoed fields and the observed guest cycle all still belong to the first command. The FIFO bursts alternate address-latch and data cycles to offsets 0x1E and 0x5F on a small guest model. Reading the bytes back shows that the latch reload before each byte lands where the host intended.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int PEND_BIT = 25;
  localparam int DIR_BIT  = 23;
  localparam int DEV_BIT  = 20;
  localparam int RSEL_BIT = 16;
  localparam int BYTE_W   = 8;

  typedef struct packed {
    logic              dir;
    logic              dev;
    logic              rsel;
    logic [BYTE_W-1:0] payload;
  } mbx_cmd_t;

  typedef enum logic {ST_IDLE, ST_RUN} mbx_st_t;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS = 12'h200
) (
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  input  logic              busy,
  output logic              hit,
  output logic              accept,
  output mbx_cmd_t          cmd
);
  logic rsvd_unused;

  always_comb begin
    hit         = (host_addr == CMD_OFS);
    accept      = host_we && hit && !busy;
    cmd.dir     = host_wdata[DIR_BIT];
    cmd.dev     = host_wdata[DEV_BIT];
    cmd.rsel    = host_wdata[RSEL_BIT];
    cmd.payload = host_wdata[BYTE_W-1:0];
    rsvd_unused = ^{host_wdata[31:24], host_wdata[22:21], host_wdata[19:17], host_wdata[15:8]};
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int WAIT_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (WAIT_CLKS < 2) ? 1 : $clog2(WAIT_CLKS);

  mbx_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_RUN;
        cnt_d = CW'(WAIT_CLKS - 1);
      end
      ST_RUN: if (cnt_q == '0) begin
        st_d = ST_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign last = busy && (cnt_q == '0);
endmodule

// File: rtl/mbx_data_reg.sv
module mbx_data_reg
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  mbx_cmd_t          cmd_in,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_byte,
  output mbx_cmd_t          cmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (load_en) begin
      cmd_q <= cmd_in;
    end else if (cap_en) begin
      cmd_q.payload <= cap_byte;
    end
  end
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS   = 12'h200,
  parameter int                WAIT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic [1:0]        gst_cs,
  output logic              gst_ale,
  output logic              gst_wr,
  output logic              gst_rd,
  output logic [7:0]        gst_dout,
  output logic              gst_doe,
  input  logic [7:0]        gst_din
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       hit, accept, busy, last;
  mbx_cmd_t   cmd_in, cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  mbx_cmd_decode #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS)) u_dec (
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .busy(busy), .hit(hit), .accept(accept), .cmd(cmd_in)
  );

  mbx_seq #(.WAIT_CLKS(WAIT_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .start(accept), .busy(busy), .last(last)
  );

  mbx_data_reg u_data (
    .clk(clk), .rst_n(rst_core_n), .load_en(accept), .cmd_in(cmd_in),
    .cap_en(last && cmd_q.rsel && !cmd_q.dir), .cap_byte(gst_din), .cmd_q(cmd_q)
  );

  always_comb begin
    gst_cs   = '0;
    gst_ale  = busy && !cmd_q.rsel;
    gst_wr   = busy && cmd_q.rsel && cmd_q.dir;
    gst_rd   = busy && cmd_q.rsel && !cmd_q.dir;
    gst_doe  = gst_ale || gst_wr;
    gst_dout = cmd_q.payload;
    if (busy) gst_cs[cmd_q.dev] = 1'b1;
  end

  always_comb begin
    host_rdata = '0;
    if (hit) begin
      host_rdata[PEND_BIT]     = busy;
      host_rdata[DIR_BIT]      = cmd_q.dir;
      host_rdata[DEV_BIT]      = cmd_q.dev;
      host_rdata[RSEL_BIT]     = cmd_q.rsel;
      host_rdata[BYTE_W-1:0]   = cmd_q.payload;
    end
  end
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CMD_OFS   = 12'h200,
  parameter int                WAIT_CLKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [1:0]        gst_cs,
  input logic              gst_ale,
  input logic              gst_wr,
  input logic              gst_rd,
  input logic              pend,
  input logic              dir_q,
  input logic              dev_q,
  input logic              rsel_q
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (!pend)  run_cnt <= '0;
    else             run_cnt <= run_cnt + 16'd1;
  end

  AST_ACCEPT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && host_we && host_addr == CMD_OFS) |=> pend); // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> (run_cnt == 16'(WAIT_CLKS))); // R3
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && host_we) |=> ($stable(dir_q) && $stable(dev_q) && $stable(rsel_q))); // R8
  AST_CS_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (gst_cs == 2'b00)); // R4
  AST_CS_FOLLOWS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (gst_cs == (dev_q ? 2'b10 : 2'b01))); // R4
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gst_ale, gst_wr, gst_rd})); // R9
  AST_STROBE_DURING_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (gst_ale || gst_wr || gst_rd)); // R9
endmodule

bind mbx_bridge mbx_bridge_chk #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .WAIT_CLKS(WAIT_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .gst_cs(gst_cs), .gst_ale(gst_ale), .gst_wr(gst_wr), .gst_rd(gst_rd),
  .pend(busy), .dir_q(cmd_q.dir), .dev_q(cmd_q.dev), .rsel_q(cmd_q.rsel)
);

// File: tb/mbx_bridge_bench.sv
module mbx_bridge_bench;
  localparam int WAIT = 4;
  localparam logic [11:0] OFS = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [11:0] host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic [1:0]  gst_cs;
  logic        gst_ale, gst_wr, gst_rd, gst_doe;
  logic [7:0]  gst_dout, gst_din;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbx_bridge #(.WAIT_CLKS(WAIT)) u_mbx_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .gst_cs(gst_cs),
    .gst_ale(gst_ale), .gst_wr(gst_wr), .gst_rd(gst_rd),
    .gst_dout(gst_dout), .gst_doe(gst_doe), .gst_din(gst_din)
  );

  // guest peripheral model: two devices, latch plus 256-byte space each
  logic [7:0] gmem [2][256];
  logic [7:0] glat [2];
  logic [7:0] emem [2][256];
  logic [7:0] elat [2];

  initial begin
    for (int d = 0; d < 2; d++) begin
      glat[d] = 8'h00; elat[d] = 8'h00;
      for (int a = 0; a < 256; a++) begin
        gmem[d][a] = 8'(a) ^ (d == 1 ? 8'h3C : 8'hC3);
        emem[d][a] = 8'(a) ^ (d == 1 ? 8'h3C : 8'hC3);
      end
    end
  end

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (gst_cs[d] && gst_ale && gst_doe) glat[d] <= gst_dout;
      if (gst_cs[d] && gst_wr && gst_doe)  gmem[d][glat[d]] <= gst_dout;
    end
  end

  always_comb begin
    gst_din = 8'hEE;
    if (gst_cs[0] && gst_rd) gst_din = gmem[0][glat[0]];
    if (gst_cs[1] && gst_rd) gst_din = gmem[1][glat[1]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard: {cs, ale, wr, rd, dout}
  logic [12:0] exp_q [$];
  logic [2:0]  prev_strb = 3'b000;
  logic [12:0] cur_ev;
  int          strb_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({gst_ale, gst_wr, gst_rd} != 3'b000 && prev_strb == 3'b000) begin
        cur_ev = {gst_cs, gst_ale, gst_wr, gst_rd, (gst_doe ? gst_dout : 8'h00)};
        if (exp_q.size() == 0) begin
          compared++; mismatched++;
          $display("FAIL R8 unexpected guest cycle actual=%h expected=none", cur_ev);
        end else begin
          check("R4/R5/R6/R7 guest cycle", 32'(cur_ev), 32'(exp_q.pop_front()));
        end
        strb_len = 1;
      end else if ({gst_ale, gst_wr, gst_rd} != 3'b000) begin
        strb_len++;
      end else if (prev_strb != 3'b000) begin
        check("R9 strobe length", 32'(strb_len), 32'(WAIT));
      end
      prev_strb = {gst_ale, gst_wr, gst_rd};
    end
  end

  function automatic logic [31:0] mk(bit dev, bit rsel, bit dir, logic [7:0] pl);
    logic [31:0] w = '0;
    w[23] = dir; w[20] = dev; w[16] = rsel; w[7:0] = pl;
    return w;
  endfunction

  task automatic wait_idle();
    while (host_rdata[25]) @(negedge clk);
  endtask

  task automatic push_exp(bit dev, bit rsel, bit dir, logic [7:0] pl);
    logic [1:0] cs = dev ? 2'b10 : 2'b01;
    exp_q.push_back({cs, !rsel, rsel && dir, rsel && !dir, (rsel && !dir) ? 8'h00 : pl});
  endtask

  task automatic cmd(bit dev, bit rsel, bit dir, logic [7:0] pl);
    int n;
    logic [7:0] expd;
    wait_idle();
    @(negedge clk);
    host_we = 1'b1; host_wdata = mk(dev, rsel, dir, pl);
    push_exp(dev, rsel, dir, pl);
    if (!rsel) elat[dev] = pl;
    else if (dir) emem[dev][elat[dev]] = pl;
    expd = emem[dev][elat[dev]];
    @(negedge clk);
    host_we = 1'b0;
    check("R3 pending set", 32'(host_rdata[25]), 32'd1);
    check("R10 field echo", {host_rdata[23], host_rdata[20], host_rdata[16]}, {dir, dev, rsel});
    check("R4 chip select", 32'(gst_cs), dev ? 32'd2 : 32'd1);
    n = 0;
    while (host_rdata[25]) begin n++; @(negedge clk); end
    check("R3 pending length", 32'(n), 32'(WAIT));
    check("R4 cs released", 32'(gst_cs), 32'd0);
    if (rsel && !dir) check("R7 read byte", 32'(host_rdata[7:0]), 32'(expd));
    else              check("R10 payload kept", 32'(host_rdata[7:0]), 32'(pl));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; mismatched++; compared++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_we = 1'b0; host_addr = OFS; host_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 word in reset", host_rdata, 32'h0);
    check("R1 strobes in reset", {gst_cs, gst_ale, gst_wr, gst_rd}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 word after reset", host_rdata, 32'h0);

    // R2: other offset
    host_addr = 12'h204; host_we = 1'b1; host_wdata = mk(0, 1, 1, 8'h55);
    @(negedge clk); host_we = 1'b0;
    check("R2 other offset reads zero", host_rdata, 32'h0);
    host_addr = OFS;
    repeat (2) @(negedge clk);
    check("R2 no cycle started", {host_rdata[25], 6'(gst_cs)}, 32'h0);

    // R5/R6/R7 register accesses on both devices
    cmd(0, 0, 1, 8'h21); cmd(0, 1, 1, 8'hA7);
    cmd(0, 0, 0, 8'h21); cmd(0, 1, 0, 8'h00);
    cmd(1, 0, 1, 8'h05); cmd(1, 1, 0, 8'h00);

    // FIFO bursts: device 1 second channel 0x5F, device 0 at 0x1E
    for (int i = 0; i < 3; i++) begin
      cmd(1, 0, 1, 8'h5F); cmd(1, 1, 1, 8'(8'h90 + i));
    end
    cmd(1, 0, 1, 8'h5F); cmd(1, 1, 0, 8'h00);
    cmd(1, 0, 1, 8'h1F); cmd(1, 1, 0, 8'h00);
    for (int i = 0; i < 2; i++) begin
      cmd(0, 0, 1, 8'h1E); cmd(0, 1, 0, 8'h00);
    end

    // R8: conflicting command while pending
    wait_idle();
    @(negedge clk);
    host_we = 1'b1; host_wdata = mk(0, 1, 1, 8'h3A);
    push_exp(0, 1, 1, 8'h3A);
    emem[0][elat[0]] = 8'h3A;
    @(negedge clk);
    host_wdata = mk(1, 0, 0, 8'hC4);
    @(negedge clk);
    host_we = 1'b0;
    check("R8 fields unchanged", {host_rdata[23], host_rdata[20], host_rdata[16]}, 32'b101);
    check("R8 cs unchanged", 32'(gst_cs), 32'd1);
    check("R8 payload unchanged", 32'(host_rdata[7:0]), 32'h3A);
    wait_idle();
    cmd(0, 0, 1, 8'h1E); cmd(0, 1, 0, 8'h00);

    repeat (4) @(negedge clk);
    check("R8 no extra guest cycle", 32'(exp_q.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule